// File: doc/BRIEF.md
# Cache miss type classifier

This block watches the access stream of a real set-associative or direct-mapped cache and sorts each access into one of four groups: a hit, a compulsory (cold) miss, a conflict miss or a capacity miss. Each access arrives as a block number, a valid strobe and the real cache's hit flag. One cycle later the block presents a class code and updates three running miss counters. Address decoding and data storage belong to the cache being observed, not to this block.

Two pieces of internal state drive the sorting. The first is a first-touch map, with one bit per block number, that records which blocks have ever been accessed. The second is a shadow cache. It is fully associative, uses least-recently-used replacement and holds as many lines as the real cache, but it stores tags only. Conflict misses cannot happen in a fully associative cache. A miss on a block that has been touched before is therefore a capacity miss when the shadow also misses, and a conflict miss when the shadow still holds the block. Every miss falls into exactly one class, so the three counters together add up to the total number of misses.

Top module: `miss_sorter`

## Requirements
- R1: A synchronous active-high reset clears all three counters, drops `cls_vld` and empties both the first-touch map and the shadow. After reset, the first access to any block is classified as cold.
- R2: `cls_vld` is high in the cycle after each cycle with `acc_vld` high, and low after each cycle with `acc_vld` low.
- R3: An access with `real_hit` high yields class code 2'b00 and leaves all three counters unchanged.
- R4: A miss on a block never accessed since reset yields code 2'b01 and adds one to `cold_cnt`.
- R5: A miss on a block that was accessed before and is still held by the shadow yields code 2'b10 and adds one to `conflict_cnt`.
- R6: A miss on a block that was accessed before and is absent from the shadow yields code 2'b11 and adds one to `capacity_cnt`.
- R7: The shadow is fully associative with SHADOW_LINES lines and least-recently-used replacement. Every access, including a real-cache hit, makes its block the most recently used. A shadow miss with all lines full evicts the line that has gone unused the longest.
- R8: Each counter is CNT_W bits wide (16 by default) and stops at its all-ones value instead of wrapping.
- R9: Until a counter saturates, `cold_cnt + conflict_cnt + capacity_cnt` equals the number of accesses that had `real_hit` low. With a 4-line direct-mapped real cache, the block sequence 0,4,0,4,0,4,0,4 gives 2 cold and 6 conflict misses.
- R10: The first-touch map covers all 2**BLK_W block numbers (64 by default). Each block is classified as cold exactly once between resets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | An access is presented this cycle |
| acc_blk | input | BLK_W | Block number of the access |
| real_hit | input | 1 | The observed cache hit on this access |
| cls_vld | output | 1 | Class code is valid (registered) |
| cls_code | output | 2 | 00 hit, 01 cold, 10 conflict, 11 capacity |
| cold_cnt | output | CNT_W | Saturating count of cold misses |
| conflict_cnt | output | CNT_W | Saturating count of conflict misses |
| capacity_cnt | output | CNT_W | Saturating count of capacity misses |

## Verification
Assertions check several things on every cycle:
- the valid-out timing;
- that a hit leaves the counters untouched and a cold code moves `cold_cnt` by exactly one;
- that the counters never wrap or fall;
- that an accessed block becomes most recently used in the shadow and is marked in the first-touch map.

Only the bench scenarios can show whether a miss landed in the correct class, since that depends on the access history. Such scenarios include eviction of the oldest shadow line, a real-cache hit refreshing a line's age, the 0,4 ping-pong sequence, and the sum of the counters matching the miss count.

// File: rtl/miss_sorter_pkg.sv
package miss_sorter_pkg;
  typedef enum logic [1:0] {
    CLS_HIT      = 2'b00,
    CLS_COLD     = 2'b01,
    CLS_CONFLICT = 2'b10,
    CLS_CAPACITY = 2'b11
  } miss_cls_e;
endpackage

// File: rtl/first_touch_map.sv
module first_touch_map #(
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [BLK_W-1:0] blk,
  output logic             seen
);
  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0] map_q;

  assign seen = map_q[blk];

  always_ff @(posedge clk) begin
    if (rst) map_q <= '0;
    else if (touch_en) map_q[blk] <= 1'b1;
  end

  // R10
  touched_mark_chk: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> map_q[$past(blk)]);
endmodule

// File: rtl/lru_shadow.sv
module lru_shadow #(
  parameter int LINES = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             look_en,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  // Entry 0 holds the most recently used tag, entry LINES-1 the oldest.
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] match;
  logic [LINES-1:0] shift_en;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == tag);
    end
  endgenerate

  assign hit = |match;

  // Entry i moves down when the access misses or the hit sits at or below i.
  generate
    for (g = LINES - 1; g >= 0; g--) begin : g_shift
      if (g == LINES - 1) begin : g_last
        assign shift_en[g] = !hit || match[g];
      end else begin : g_mid
        assign shift_en[g] = shift_en[g+1] || match[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (look_en) begin
      tag_q[0] <= tag;
      for (int i = 1; i < LINES; i++)
        if (shift_en[i]) tag_q[i] <= tag_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (look_en) begin
      vld_q[0] <= 1'b1;
      for (int i = 1; i < LINES; i++)
        if (shift_en[i]) vld_q[i] <= vld_q[i-1];
    end
  end

  // R7
  mru_front_chk: assert property (@(posedge clk) disable iff (rst)
    look_en |=> vld_q[0] && (tag_q[0] == $past(tag)));
  // R7
  hit_keeps_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (look_en && hit) |=> $stable(vld_q));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && (cnt != TOP)) cnt <= cnt + 1'b1;
  end

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == TOP));
  // R8
  never_falls_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/miss_sorter.sv
module miss_sorter #(
  parameter int BLK_W        = 6,
  parameter int SHADOW_LINES = 4,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic [BLK_W-1:0] acc_blk,
  input  logic             real_hit,
  output logic             cls_vld,
  output logic [1:0]       cls_code,
  output logic [CNT_W-1:0] cold_cnt,
  output logic [CNT_W-1:0] conflict_cnt,
  output logic [CNT_W-1:0] capacity_cnt
);
  import miss_sorter_pkg::*;

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic      seen;
  logic      sh_hit;
  miss_cls_e nxt_cls;
  miss_cls_e cls_q;

  first_touch_map #(.BLK_W(BLK_W)) u_touch (
    .clk(clk), .rst(rst), .touch_en(acc_vld), .blk(acc_blk), .seen(seen)
  );

  lru_shadow #(.LINES(SHADOW_LINES), .TAG_W(BLK_W)) u_shadow (
    .clk(clk), .rst(rst), .look_en(acc_vld), .tag(acc_blk), .hit(sh_hit)
  );

  always_comb begin
    if (real_hit)     nxt_cls = CLS_HIT;
    else if (!seen)   nxt_cls = CLS_COLD;
    else if (!sh_hit) nxt_cls = CLS_CAPACITY;
    else              nxt_cls = CLS_CONFLICT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_vld <= 1'b0;
      cls_q   <= CLS_HIT;
    end else begin
      cls_vld <= acc_vld;
      if (acc_vld) cls_q <= nxt_cls;
    end
  end

  assign cls_code = cls_q;

  sat_counter #(.W(CNT_W)) u_cold (
    .clk(clk), .rst(rst), .inc(acc_vld && (nxt_cls == CLS_COLD)), .cnt(cold_cnt)
  );
  sat_counter #(.W(CNT_W)) u_conf (
    .clk(clk), .rst(rst), .inc(acc_vld && (nxt_cls == CLS_CONFLICT)), .cnt(conflict_cnt)
  );
  sat_counter #(.W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .inc(acc_vld && (nxt_cls == CLS_CAPACITY)), .cnt(capacity_cnt)
  );

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_vld |=> cls_vld);
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |=> !cls_vld);
  // R3
  hit_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (cls_vld && cls_code == 2'b00) |->
      ($stable(cold_cnt) && $stable(conflict_cnt) && $stable(capacity_cnt)));
  // R4
  cold_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cls_vld && cls_code == 2'b01 && $past(cold_cnt) != CNT_TOP) |->
      (cold_cnt == $past(cold_cnt) + 1'b1));
endmodule

// File: tb/miss_sorter_test.sv
module miss_sorter_test;
  localparam int BW = 6;
  localparam int NL = 4;
  localparam int CW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_vld = 1'b0;
  logic [BW-1:0] acc_blk = '0;
  logic          real_hit = 1'b0;
  logic          cls_vld;
  logic [1:0]    cls_code;
  logic [CW-1:0] cold_cnt, conflict_cnt, capacity_cnt;

  miss_sorter #(.BLK_W(BW), .SHADOW_LINES(NL), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_blk(acc_blk), .real_hit(real_hit),
    .cls_vld(cls_vld), .cls_code(cls_code), .cold_cnt(cold_cnt),
    .conflict_cnt(conflict_cnt), .capacity_cnt(capacity_cnt)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench reference state
  bit seen_m [64];
  int sh_tag [NL];
  int sh_n;
  int dm_tag [4];
  bit dm_v [4];
  int e_cold, e_conf, e_cap, e_miss;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) seen_m[i] = 1'b0;
    for (int i = 0; i < 4; i++) dm_v[i] = 1'b0;
    sh_n = 0;
    e_cold = 0; e_conf = 0; e_cap = 0; e_miss = 0;
  endtask

  function automatic int sat_inc(input int v);
    return (v == CMAX) ? v : v + 1;
  endfunction

  task automatic check_counts(input string req);
    chk(cold_cnt == CW'(e_cold), req, int'(cold_cnt), e_cold);
    chk(conflict_cnt == CW'(e_conf), req, int'(conflict_cnt), e_conf);
    chk(capacity_cnt == CW'(e_cap), req, int'(capacity_cnt), e_cap);
  endtask

  // mode 0: real hit from a 4-line direct-mapped model, 1: forced miss, 2: forced hit
  task automatic step(input int blk, input int mode, input bit do_chk);
    bit rh, shit;
    int pos, code, li;
    li = blk % 4;
    if (mode == 1) rh = 1'b0;
    else if (mode == 2) rh = 1'b1;
    else rh = dm_v[li] && (dm_tag[li] == blk);
    dm_v[li] = 1'b1; dm_tag[li] = blk;
    shit = 1'b0; pos = 0;
    for (int i = 0; i < sh_n; i++) if (sh_tag[i] == blk) begin shit = 1'b1; pos = i; end
    if (!shit) begin
      pos = (sh_n < NL) ? sh_n : NL - 1;
      if (sh_n < NL) sh_n++;
    end
    for (int i = pos; i > 0; i--) sh_tag[i] = sh_tag[i-1];
    sh_tag[0] = blk;
    if (rh) code = 0;
    else if (!seen_m[blk]) code = 1;
    else if (!shit) code = 3;
    else code = 2;
    seen_m[blk] = 1'b1;
    if (code != 0) e_miss++;
    if (code == 1) e_cold = sat_inc(e_cold);
    if (code == 2) e_conf = sat_inc(e_conf);
    if (code == 3) e_cap = sat_inc(e_cap);
    acc_vld = 1'b1; acc_blk = BW'(blk); real_hit = rh;
    @(negedge clk);
    if (do_chk) begin
      chk(cls_vld == 1'b1, "R2", int'(cls_vld), 1);
      case (code)
        0: chk(cls_code == 2'b00, "R3", int'(cls_code), code);
        1: chk(cls_code == 2'b01, "R4", int'(cls_code), code);
        2: chk(cls_code == 2'b10, "R5", int'(cls_code), code);
        default: chk(cls_code == 2'b11, "R6", int'(cls_code), code);
      endcase
      check_counts("R7 R9 counters");
    end
  endtask

  task automatic idle(input int n);
    acc_vld = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    acc_vld = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
    chk(cls_vld == 1'b0, "R1 cls_vld", int'(cls_vld), 0);
    check_counts("R1");
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    @(negedge clk);
    do_reset();

    // R9: ping-pong 0,4 on a 4-line direct-mapped cache: 2 cold, 6 conflict
    for (int k = 0; k < 8; k++) step((k % 2) * 4, 0, 1'b1);
    chk(cold_cnt == 16'd2, "R9 cold", int'(cold_cnt), 2);
    chk(conflict_cnt == 16'd6, "R9 conflict", int'(conflict_cnt), 6);

    // R3: a real hit changes no counter
    step(1, 0, 1'b1);
    step(1, 0, 1'b1);

    // R2: idle cycle drops cls_vld
    idle(1);
    chk(cls_vld == 1'b0, "R2 idle", int'(cls_vld), 0);

    // R7: LRU eviction, and a real hit refreshing a line's age
    for (int b = 16; b < 20; b++) step(b, 1, 1'b1);
    step(16, 1, 1'b1);                 // R5 conflict
    step(20, 1, 1'b1);                 // evicts 17
    step(17, 1, 1'b1);                 // R6 capacity
    chk(cls_code == 2'b11, "R7 evict oldest", int'(cls_code), 3);
    step(19, 2, 1'b1);                 // real hit refreshes 19
    step(21, 1, 1'b1);                 // evicts 16, not 19
    step(19, 1, 1'b1);
    chk(cls_code == 2'b10, "R7 hit refresh", int'(cls_code), 2);
    step(16, 1, 1'b1);
    chk(cls_code == 2'b11, "R7 evicted", int'(cls_code), 3);

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      int b;
      b = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 63)) : int'($urandom_range(0, 11));
      step(b, ($urandom_range(0, 9) == 0) ? 1 : 0, 1'b1);
      if ($urandom_range(0, 5) == 0) idle(1);
    end
    idle(1);
    chk(int'(cold_cnt) + int'(conflict_cnt) + int'(capacity_cnt) == e_miss, "R9 total",
        int'(cold_cnt) + int'(conflict_cnt) + int'(capacity_cnt), e_miss);

    // R10: every block cold exactly once after reset
    do_reset();
    for (int b = 0; b < 64; b++) step(b, 1, 1'b1);
    chk(cold_cnt == 16'd64, "R10 all cold", int'(cold_cnt), 64);
    step(0, 1, 1'b1);
    chk(cls_code != 2'b01, "R10 not cold twice", int'(cls_code), 3);

    // R8: capacity counter saturation with five blocks over a 4-line shadow
    for (int k = 0; k < CMAX + 8; k++) step(40 + (k % 5), 1, 1'b0);
    idle(1);
    chk(capacity_cnt == 16'hFFFF, "R8 saturate", int'(capacity_cnt), CMAX);
    check_counts("R8");
    step(40, 1, 1'b1);
    chk(capacity_cnt == 16'hFFFF, "R8 hold", int'(capacity_cnt), CMAX);

    // R1: reset mid-run, then first access is cold again
    do_reset();
    step(40, 1, 1'b1);
    chk(cls_code == 2'b01, "R1 cold after reset", int'(cls_code), 1);
    idle(2);

    done = 1'b1;
    finish_run();
  end
endmodule